// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting channel for an interval timer. A host talks to it over a byte-wide port: one write strobe that carries either a control byte or a count byte, and one read strobe that steps through the bytes of the live count. The control byte picks how count bytes are transferred, which of two waveform rules drives the OUT pin, and whether the count runs in binary or in four-digit BCD. The gate input of a full timer is taken as permanently enabled, so the channel has no gate pin.

The first waveform rule is a divide-by-N rate generator. OUT idles high, drops for exactly one clock each time the count reaches 1, and the channel reloads itself and repeats without further host action. The second rule is a software-fired strobe. Writing the count is the trigger. OUT drops for one clock N+1 clocks after that write and then stays high until the host writes a count again. A null-count flag tells the host that a written value has not yet reached the counting element.

Top module: `pit_channel`

## Requirements
- R1: A write with `wr_ctrl`=1 loads the channel setup from `wr_data`. Bit 0 selects the counting radix (1 = BCD, 0 = binary), bits 3:1 select the waveform rule (010 = rate generator, 100 = strobe), and bits 5:4 select the byte format. A control byte whose bits 5:4 are 00 is ignored and changes nothing, including the null flag.
- R2: Byte format 01 writes only the low byte and clears the high byte. Format 10 writes only the high byte and clears the low byte. Format 11 takes the low byte and then the high byte, alternating on each data write, and a count takes effect only when its high byte is written. A control write resets the alternation to the low byte.
- R3: A completed count write is copied into the counting element on the next clock, and decrementing starts on the clock after that. `rd_data` shows the live count using the same byte format: format 11 shows the low byte first, and each `rd_en` pulse switches to the other byte.
- R4: In rate-generator mode OUT is high, goes low for exactly one clock while the count equals 1, and the count then reloads. For a count N written at edge k, OUT is low after edges k+N, k+2N, and so on.
- R5: In rate-generator mode a written count of 1 is rejected. It is not loaded, the null flag stays set, and no pulse appears.
- R6: In strobe mode a count N completed at edge k makes OUT low after edge k+N+1, for exactly one clock.
- R7: After a strobe OUT stays high until a new count is written. A new count re-arms the strobe.
- R8: A count of 0 means 65536 in binary and 10000 in BCD. In BCD every nibble counts 9 down to 0.
- R9: The null flag `null_o` is set by every accepted control or data write and cleared when the count is copied into the counting element.
- R10: An accepted control write stops counting and forces OUT high on the next clock. Waveform codes other than 010 and 100 leave OUT high after a count is loaded.
- R11: After reset OUT is high, `null_o` is 0 and the count reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one byte per clock |
| wr_ctrl | input | 1 | 1 = byte is a control byte, 0 = count byte |
| wr_data | input | 8 | Byte being written |
| rd_en | input | 1 | Read advance pulse for the two-byte format |
| rd_data | output | 8 | Selected byte of the live count |
| out_o | output | 1 | Channel waveform output |
| null_o | output | 1 | Written count not yet in the counting element |

## Verification
The assertions assume that `wr_en` is held for exactly one clock per byte and that `rd_en` is never raised in the same clock as a control write. They also assume that the host does not change the waveform code while a count is loading. The bench drives every byte as a single-clock pulse placed between edges. It only reads while no write is in flight, and it always writes a new control byte before a data sequence in a different format. As a result, each expected pulse edge in the scoreboard follows only from the write-completion edge and the count.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;
   typedef enum logic [1:0] {
      FMT_NONE = 2'b00,
      FMT_LO   = 2'b01,
      FMT_HI   = 2'b10,
      FMT_BOTH = 2'b11
   } fmt_e;

   typedef struct packed {
      fmt_e       fmt;
      logic [2:0] wave;
      logic       bcd;
   } setup_t;

   localparam logic [2:0] WAVE_RATE   = 3'b010;
   localparam logic [2:0] WAVE_STROBE = 3'b100;
endpackage

// File: rtl/pit_decr.sv
`timescale 1ns/1ps
module pit_decr #(
   parameter int CNT_W  = 16,
   parameter bit BCD_EN = 1'b1
) (
   input  logic [CNT_W-1:0] val_i,
   input  logic             bcd_i,
   output logic [CNT_W-1:0] dec_o
);
   localparam int NIB = CNT_W / 4;

   logic [CNT_W-1:0] bin_dec;
   assign bin_dec = val_i - CNT_W'(1);

   generate
      if (BCD_EN) begin : g_bcd
         logic [CNT_W-1:0] bcd_dec;
         logic [NIB:0]     brw;
         assign brw[0] = 1'b1;
         for (genvar g = 0; g < NIB; g++) begin : g_nib
            logic [3:0] nib;
            assign nib = val_i[4*g +: 4];
            assign bcd_dec[4*g +: 4] = !brw[g] ? nib :
                                       (nib == 4'd0) ? 4'd9 : nib - 4'd1;
            assign brw[g+1] = brw[g] & (nib == 4'd0);
         end
         assign dec_o = bcd_i ? bcd_dec : bin_dec;
      end else begin : g_bin
         logic unused_bcd;
         assign unused_bcd = bcd_i;
         assign dec_o = bin_dec;
      end
   endgenerate
endmodule

// File: rtl/pit_host_port.sv
`timescale 1ns/1ps
module pit_host_port
   import pit_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_ctrl,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [CNT_W-1:0]  live_cnt,
   output setup_t            setup_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              load_q,
   output logic              ctrl_acc,
   output logic              null_q,
   output logic [BYTE_W-1:0] rd_data
);
   localparam int HI_W = CNT_W - BYTE_W;

   logic             data_wr;
   logic             wr_ptr;
   logic             rd_ptr;
   logic             done;
   logic [CNT_W-1:0] new_cnt;

   assign ctrl_acc = wr_en & wr_ctrl & (wr_data[5:4] != 2'b00);
   assign data_wr  = wr_en & ~wr_ctrl & (setup_q.fmt != FMT_NONE);

   always_comb begin
      new_cnt = cnt_q;
      done    = 1'b0;
      if (data_wr) begin
         unique case (setup_q.fmt)
            FMT_LO: begin
               new_cnt = {{HI_W{1'b0}}, wr_data};
               done    = 1'b1;
            end
            FMT_HI: begin
               new_cnt = {wr_data[HI_W-1:0], {BYTE_W{1'b0}}};
               done    = 1'b1;
            end
            FMT_BOTH: begin
               if (!wr_ptr) begin
                  new_cnt[BYTE_W-1:0] = wr_data;
               end else begin
                  new_cnt[CNT_W-1:BYTE_W] = wr_data[HI_W-1:0];
                  done = 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_q <= '0;
         cnt_q   <= '0;
         load_q  <= 1'b0;
         null_q  <= 1'b0;
         wr_ptr  <= 1'b0;
         rd_ptr  <= 1'b0;
      end else begin
         load_q <= 1'b0;
         if (ctrl_acc) begin
            setup_q <= setup_t'(wr_data[5:0]);
            wr_ptr  <= 1'b0;
            rd_ptr  <= 1'b0;
            null_q  <= 1'b1;
         end else begin
            if (data_wr) begin
               cnt_q  <= new_cnt;
               null_q <= 1'b1;
               if (setup_q.fmt == FMT_BOTH) wr_ptr <= ~wr_ptr;
               if (done && !(setup_q.wave == WAVE_RATE && new_cnt == CNT_W'(1)))
                  load_q <= 1'b1;
            end else if (load_q) begin
               null_q <= 1'b0;
            end
            if (rd_en && setup_q.fmt == FMT_BOTH) rd_ptr <= ~rd_ptr;
         end
      end
   end

   always_comb begin
      unique case (setup_q.fmt)
         FMT_HI:   rd_data = live_cnt[CNT_W-1:BYTE_W];
         FMT_BOTH: rd_data = rd_ptr ? live_cnt[CNT_W-1:BYTE_W] : live_cnt[BYTE_W-1:0];
         default:  rd_data = live_cnt[BYTE_W-1:0];
      endcase
   end
endmodule

// File: rtl/pit_counter.sv
`timescale 1ns/1ps
module pit_counter
   import pit_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter bit BCD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] init_i,
   input  logic [2:0]       wave_i,
   input  logic             bcd_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             out_o
);
   logic [CNT_W-1:0] ce_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] dec;
   logic             run_q;
   logic             shot_q;

   pit_decr #(.CNT_W(CNT_W), .BCD_EN(BCD_EN)) u_decr (
      .val_i (ce_q),
      .bcd_i (bcd_i),
      .dec_o (dec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q     <= '0;
         reload_q <= '0;
         run_q    <= 1'b0;
         shot_q   <= 1'b0;
         out_o    <= 1'b1;
      end else if (stop_i) begin
         run_q <= 1'b0;
         out_o <= 1'b1;
      end else if (load_i) begin
         ce_q     <= init_i;
         reload_q <= init_i;
         run_q    <= (wave_i == WAVE_RATE) || (wave_i == WAVE_STROBE);
         shot_q   <= 1'b0;
         out_o    <= 1'b1;
      end else if (run_q) begin
         out_o <= 1'b1;
         if (wave_i == WAVE_RATE) begin
            if (ce_q == CNT_W'(1)) begin
               ce_q <= reload_q;
            end else begin
               ce_q <= dec;
               if (dec == CNT_W'(1)) out_o <= 1'b0;
            end
         end else begin
            ce_q <= dec;
            if (ce_q == CNT_W'(1) && !shot_q) begin
               out_o  <= 1'b0;
               shot_q <= 1'b1;
            end
         end
      end else begin
         out_o <= 1'b1;
      end
   end

   assign cnt_o = ce_q;
endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
   import pit_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16,
   parameter bit BCD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_ctrl,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [BYTE_W-1:0] rd_data,
   output logic              out_o,
   output logic              null_o
);
   generate
      if (CNT_W != 2 * BYTE_W) begin : g_bad_width
         $error("pit_channel: CNT_W must be two bytes wide");
      end
      if (BYTE_W < 6) begin : g_bad_byte
         $error("pit_channel: BYTE_W must hold the six setup bits");
      end
      if (CNT_W % 4 != 0) begin : g_bad_nib
         $error("pit_channel: CNT_W must be a whole number of nibbles");
      end
   endgenerate

   setup_t           setup;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] live_cnt;
   logic             load;
   logic             ctrl_acc;

   pit_host_port #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_ctrl  (wr_ctrl),
      .wr_data  (wr_data),
      .rd_en    (rd_en),
      .live_cnt (live_cnt),
      .setup_q  (setup),
      .cnt_q    (cnt_w),
      .load_q   (load),
      .ctrl_acc (ctrl_acc),
      .null_q   (null_o),
      .rd_data  (rd_data)
   );

   pit_counter #(.CNT_W(CNT_W), .BCD_EN(BCD_EN)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .stop_i (ctrl_acc),
      .load_i (load),
      .init_i (cnt_w),
      .wave_i (setup.wave),
      .bcd_i  (setup.bcd),
      .cnt_o  (live_cnt),
      .out_o  (out_o)
   );
endmodule

// File: rtl/pit_channel_chk.sv
`timescale 1ns/1ps
module pit_channel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       wr_ctrl,
   input logic [1:0] wr_fmt,
   input logic       out_o,
   input logic       null_o
);
   AST_LOW_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !out_o |=> out_o); // R4

   AST_CTRL_SETS_NULL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ctrl && wr_fmt != 2'b00) |=> null_o); // R9

   AST_CTRL_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ctrl && wr_fmt != 2'b00) |=> out_o); // R10

   AST_NULL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!null_o && !wr_en) |=> !null_o); // R9

   AST_IGNORED_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ctrl && wr_fmt == 2'b00 && !null_o) |=> !null_o); // R1
endmodule

bind pit_channel pit_channel_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_ctrl (wr_ctrl),
   .wr_fmt  (wr_data[5:4]),
   .out_o   (out_o),
   .null_o  (null_o)
);

// File: tb/pit_channel_bench.sv
`timescale 1ns/1ps
module pit_channel_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_ctrl = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       out_o;
   logic       null_o;

   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   int    lows_seen = 0;
   int    exp_q[$];
   bit    mon_en = 1'b0;
   bit    finished = 1'b0;
   logic  exp_low;
   string cur_req = "R6";

   pit_channel u_pit_channel (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ctrl(wr_ctrl),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .out_o(out_o), .null_o(null_o)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   // monitor: pops expected low-pulse edges and compares OUT
   always @(negedge clk) begin
      if (mon_en) begin
         while (exp_q.size() > 0 && exp_q[0] < cyc) begin
            errors++;
            checks++;
            $display("FAIL %s: pulse expected after edge %0d, actual none, expected low",
                     cur_req, exp_q[0]);
            void'(exp_q.pop_front());
         end
         exp_low = (exp_q.size() > 0 && exp_q[0] == cyc);
         if (exp_low) void'(exp_q.pop_front());
         if (exp_low || !out_o) begin
            checks++;
            if (out_o !== !exp_low) begin
               errors++;
               $display("FAIL %s: OUT after edge %0d actual %b expected %b",
                        cur_req, cyc, out_o, !exp_low);
            end
         end
         if (!out_o) lows_seen++;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input bit c, input logic [7:0] d, output int k);
      wr_en = 1'b1; wr_ctrl = c; wr_data = d;
      k = cyc + 1;
      @(negedge clk);
      wr_en = 1'b0; wr_ctrl = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      if (!finished) begin
         finished = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #950us;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      int k;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      check("R11 out", out_o, 1);
      check("R11 null", null_o, 0);
      check("R11 count", rd_data, 0);
      mon_en = 1'b1;

      // strobe, two-byte binary
      cur_req = "R6";
      wr(1, 8'h38, k);
      check("R9 null after ctrl", null_o, 1);
      wr(0, 8'h05, k);
      check("R2 out before high byte", out_o, 1);
      wr(0, 8'h00, k);
      exp_q.push_back(k + 6);
      check("R9 null before transfer", null_o, 1);
      idle(1);
      check("R9 null cleared", null_o, 0);
      check("R3 loaded count", rd_data, 5);
      idle(1);
      check("R3 first decrement", rd_data, 4);
      rd_en = 1'b1;
      idle(1);
      rd_en = 1'b0;
      check("R3 high byte read", rd_data, 0);
      idle(40);
      cur_req = "R7";
      check("R7 single strobe", lows_seen, 1);

      // retrigger
      wr(0, 8'h03, k);
      wr(0, 8'h00, k);
      exp_q.push_back(k + 4);
      idle(30);
      check("R7 retrigger", lows_seen, 2);

      // format-00 control byte ignored
      cur_req = "R1";
      wr(0, 8'h09, k);
      wr(0, 8'h00, k);
      exp_q.push_back(k + 10);
      idle(3);
      wr(1, 8'h00, k);
      check("R1 ignored ctrl null", null_o, 0);
      idle(20);
      check("R1 strobe survives", lows_seen, 3);

      // rate generator, low byte only
      cur_req = "R4";
      wr(1, 8'h14, k);
      wr(0, 8'h04, k);
      for (int i = 1; i <= 5; i++) exp_q.push_back(k + 4 * i);
      idle(k + 21 - cyc);
      cur_req = "R10";
      wr(1, 8'h14, k);
      check("R10 out high after ctrl", out_o, 1);
      idle(20);
      check("R4 rate pulses", lows_seen, 8);

      // rate count of one rejected
      cur_req = "R5";
      wr(0, 8'h01, k);
      idle(2);
      check("R5 null stays set", null_o, 1);
      idle(20);
      check("R5 no pulse", lows_seen, 8);

      // BCD strobe
      cur_req = "R8";
      wr(1, 8'h19, k);
      wr(0, 8'h12, k);
      exp_q.push_back(k + 13);
      idle(4);
      check("R8 BCD digit", rd_data, 8'h09);
      idle(20);
      check("R8 BCD strobe", lows_seen, 9);

      // high byte only
      cur_req = "R2";
      wr(1, 8'h28, k);
      wr(0, 8'h01, k);
      exp_q.push_back(k + 257);
      idle(1);
      check("R2 high byte format", rd_data, 1);
      idle(270);
      check("R2 high byte strobe", lows_seen, 10);

      // BCD zero
      cur_req = "R8";
      wr(1, 8'h39, k);
      wr(0, 8'h00, k);
      wr(0, 8'h00, k);
      exp_q.push_back(k + 10001);
      idle(2);
      check("R8 BCD wrap", rd_data, 8'h99);
      idle(10010);
      check("R8 BCD zero strobe", lows_seen, 11);

      // binary zero
      wr(1, 8'h38, k);
      wr(0, 8'h00, k);
      wr(0, 8'h00, k);
      exp_q.push_back(k + 65537);
      idle(2);
      check("R8 binary wrap", rd_data, 8'hFF);
      idle(65545);
      check("R8 binary zero strobe", lows_seen, 12);

      // control write stops a running strobe
      cur_req = "R10";
      wr(0, 8'h0A, k);
      wr(0, 8'h00, k);
      idle(4);
      wr(1, 8'h38, k);
      idle(25);
      check("R10 stop mid count", lows_seen, 12);

      // unsupported waveform code
      wr(1, 8'h30, k);
      wr(0, 8'h03, k);
      wr(0, 8'h00, k);
      idle(20);
      check("R10 unsupported code", lows_seen, 12);
      check("R6 queue drained", exp_q.size(), 0);
      summary();
   end
endmodule